// File: doc/BRIEF.md
# Framed Byte Transmitter with CRC-16 and Periodic Status Frames

This block sits between a producer of payload bytes and a byte-wide UART transmitter. The producer streams a payload into a local buffer and marks its last byte. The block then sends the payload as one frame: a fixed marker byte, a byte giving the payload size, the payload itself, and a 16-bit check word. The check word is computed over the size byte and the payload. The UART side pulls bytes through a valid/ready handshake. The buffer holds the most recent data frame, so a retransmit request can send that frame again exactly as before.

The block keeps a count of completed frames. Whenever that count is a multiple of three, it sends a four-byte status frame on its own. The status frame carries an exponent, a count of non-zero trits and a token index, all taken from side inputs at the moment the status frame starts. The token index is reduced modulo 65535 before it is sent.

Top module: `ftx_framer`

## Requirements
- R1: Each frame leaves on `tx_data` in this order: marker 0xAA, size byte, payload bytes in arrival order, check word high byte, check word low byte.
- R2: The size byte equals the number of payload bytes and lies in 1..255. A payload ends at the byte accepted with `in_last` high, or at the 255th accepted byte, whichever comes first.
- R3: The check word is CRC-16 with polynomial 0x1021, start value 0xFFFF, processed most-significant bit first, with no reflection and no final inversion. It covers the size byte and then the payload, never the marker, and restarts for every frame.
- R4: The frame count is zero after reset and rises by one per completed frame, status frames included. When the block is idle and the count modulo 3 is 0, it sends a status frame before anything else, so the first frame after reset is a status frame.
- R5: A status frame has size byte 4. Its payload is the exponent (`st_exp`), then the trit count (`st_trits`), then the 16-bit token index, high byte first. All fields are captured when the status frame starts.
- R6: The token index equals `st_token` modulo 65535, so 65535 gives 0, 65536 gives 1 and 0xFFFFFFFF gives 0.
- R7: A one-cycle pulse on `retx_req` sends the most recent data frame again with identical bytes, and leaves the frame count unchanged.
- R8: A `retx_req` pulse is dropped when no data frame has been sent since reset, or when collection of a new payload has started.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged.
- R10: `in_ready` is low whenever a frame is being sent, so no payload byte is accepted while `tx_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Payload byte offered |
| in_ready | output | 1 | Block accepts a payload byte this cycle |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Offered byte is the last of its payload |
| st_exp | input | 8 | Signed exponent for status frames |
| st_trits | input | 8 | Non-zero trit count for status frames |
| st_token | input | 32 | Token number; sent modulo 65535 |
| retx_req | input | 1 | Pulse: send the last data frame again |
| tx_valid | output | 1 | Output byte offered to the UART |
| tx_ready | input | 1 | UART takes the output byte |
| tx_data | output | 8 | Output byte |

## Verification
The assertions assume that the UART side follows a plain valid/ready rule, and that `retx_req` arrives as a one-cycle pulse. They place no bound on how long `tx_ready` may stay low. The stimulus holds `tx_ready` low in a pseudo-random pattern of stalls. It drives payload bytes only when `in_ready` is high, and pulses `retx_req` only once the block has gone quiet. The status inputs change only between frames that are not status frames, so each capture sees a stable value.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_WAIT
  } seq_e;

  // one byte of CRC-16, MSB first, no reflection
  function automatic logic [15:0] crc_step(input logic [15:0] c,
                                           input logic [7:0]  d,
                                           input logic [15:0] poly);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++) begin
      r = r[15] ? ((r << 1) ^ poly) : (r << 1);
    end
    return r;
  endfunction

  // 32-bit value modulo 65535 by end-around-carry folding
  function automatic logic [15:0] tok_mod(input logic [31:0] t);
    logic [16:0] s;
    logic [15:0] y;
    s = {1'b0, t[31:16]} + {1'b0, t[15:0]};
    y = s[15:0] + {15'd0, s[16]};
    return (y == 16'hFFFF) ? 16'h0000 : y;
  endfunction

endpackage

// File: rtl/ftx_buf.sv
module ftx_buf #(
  parameter int DEPTH = 255,
  parameter int AW    = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/ftx_crc.sv
module ftx_crc import ftx_pkg::*; #(
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || clr) crc <= INIT;
    else if (en)    crc <= crc_step(crc, din, POLY);
  end
endmodule

// File: rtl/ftx_status.sv
module ftx_status import ftx_pkg::*; (
  input  logic        clk,
  input  logic        rst,
  input  logic        cap,
  input  logic [7:0]  exp_in,
  input  logic [7:0]  trits_in,
  input  logic [31:0] token_in,
  output logic [31:0] word
);
  always_ff @(posedge clk) begin
    if (rst)      word <= '0;
    else if (cap) word <= {exp_in, trits_in, tok_mod(token_in)};
  end
endmodule

// File: rtl/ftx_framer.sv
module ftx_framer import ftx_pkg::*; #(
  parameter int          MAX_LEN  = 255,
  parameter int          PERIOD   = 3,
  parameter logic [7:0]  SYNC     = 8'hAA,
  parameter logic [15:0] POLY     = 16'h1021,
  parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic [7:0]  st_exp,
  input  logic [7:0]  st_trits,
  input  logic [31:0] st_token,
  input  logic        retx_req,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data
);
  localparam int AW       = $clog2(MAX_LEN);
  localparam int LW       = $clog2(MAX_LEN + 1);
  localparam int IW       = LW + 2;
  localparam int PW       = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int STAT_LEN = 4;

  seq_e          state;
  logic [IW-1:0] idx;
  logic [IW-1:0] pidx;
  logic [LW-1:0] cur_len;
  logic [LW-1:0] data_len;
  logic [LW-1:0] wr_cnt;
  logic [PW-1:0] phase;
  logic          is_stat;
  logic          replaying;
  logic          have_frame;
  logic          retx_pend;
  logic          accept;
  logic          pay_end;
  logic          start_stat;
  logic          start_rep;
  logic          start_dat;
  logic          start_any;
  logic          in_span;
  logic          last_idx;
  logic [7:0]    rd_q;
  logic [7:0]    nxt_byte;
  logic [15:0]   crc;
  logic [31:0]   st_word;

  assign in_ready   = (state == ST_IDLE) && (phase != '0) && !retx_pend;
  assign accept     = in_ready && in_valid;
  assign pay_end    = in_last || (wr_cnt == LW'(MAX_LEN - 1));
  assign start_stat = (state == ST_IDLE) && (phase == '0);
  assign start_rep  = (state == ST_IDLE) && (phase != '0) && retx_pend;
  assign start_dat  = accept && pay_end;
  assign start_any  = start_stat || start_rep || start_dat;

  assign pidx     = idx - IW'(2);
  assign in_span  = (idx >= IW'(1)) && (idx <= IW'(cur_len) + IW'(1));
  assign last_idx = (idx == IW'(cur_len) + IW'(3));

  ftx_buf #(.DEPTH(MAX_LEN), .AW(AW), .DW(8)) u_buf (
    .clk     (clk),
    .wr_en   (accept),
    .wr_addr (AW'(wr_cnt)),
    .wr_data (in_data),
    .rd_addr (AW'(pidx)),
    .rd_data (rd_q)
  );

  ftx_crc #(.POLY(POLY), .INIT(CRC_INIT)) u_crc (
    .clk (clk),
    .rst (rst),
    .clr (start_any),
    .en  ((state == ST_LOAD) && in_span),
    .din (nxt_byte),
    .crc (crc)
  );

  ftx_status u_stat (
    .clk      (clk),
    .rst      (rst),
    .cap      (start_stat),
    .exp_in   (st_exp),
    .trits_in (st_trits),
    .token_in (st_token),
    .word     (st_word)
  );

  // byte selected for the current index
  always_comb begin
    if (idx == '0)
      nxt_byte = SYNC;
    else if (idx == IW'(1))
      nxt_byte = 8'(cur_len);
    else if (in_span)
      nxt_byte = is_stat ? st_word[8*(3 - int'(pidx[1:0])) +: 8] : rd_q;
    else if (idx == IW'(cur_len) + IW'(2))
      nxt_byte = crc[15:8];
    else
      nxt_byte = crc[7:0];
  end

  // retransmit bookkeeping and payload collection
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cnt     <= '0;
      data_len   <= '0;
      have_frame <= 1'b0;
      retx_pend  <= 1'b0;
    end else begin
      if (accept) begin
        if (pay_end) begin
          wr_cnt     <= '0;
          data_len   <= wr_cnt + LW'(1);
          have_frame <= 1'b1;
        end else begin
          wr_cnt     <= wr_cnt + LW'(1);
          have_frame <= 1'b0;
        end
      end
      if (start_rep)
        retx_pend <= 1'b0;
      else if (retx_req && have_frame && !accept && (wr_cnt == '0))
        retx_pend <= 1'b1;
    end
  end

  // frame sequencer with registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      cur_len   <= '0;
      phase     <= '0;
      is_stat   <= 1'b0;
      replaying <= 1'b0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          idx <= '0;
          if (start_stat) begin
            is_stat   <= 1'b1;
            replaying <= 1'b0;
            cur_len   <= LW'(STAT_LEN);
            state     <= ST_FETCH;
          end else if (start_rep) begin
            is_stat   <= 1'b0;
            replaying <= 1'b1;
            cur_len   <= data_len;
            state     <= ST_FETCH;
          end else if (start_dat) begin
            is_stat   <= 1'b0;
            replaying <= 1'b0;
            cur_len   <= wr_cnt + LW'(1);
            state     <= ST_FETCH;
          end
        end
        ST_FETCH: state <= ST_LOAD;
        ST_LOAD: begin
          tx_valid <= 1'b1;
          tx_data  <= nxt_byte;
          state    <= ST_WAIT;
        end
        ST_WAIT: begin
          if (tx_ready) begin
            tx_valid <= 1'b0;
            if (last_idx) begin
              state <= ST_IDLE;
              if (!replaying)
                phase <= (phase == PW'(PERIOD - 1)) ? '0 : phase + PW'(1);
            end else begin
              idx   <= idx + IW'(1);
              state <= ST_FETCH;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ftx_framer_chk.sv
module ftx_framer_chk #(
  parameter int         IW     = 10,
  parameter int         LW     = 8,
  parameter int         PW     = 2,
  parameter int         PERIOD = 3,
  parameter logic [7:0] SYNC   = 8'hAA
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          in_ready,
  input logic [IW-1:0] idx,
  input logic [LW-1:0] cur_len,
  input logic          is_stat,
  input logic          replaying,
  input logic [PW-1:0] phase
);
  logic frame_done;
  assign frame_done = tx_valid && tx_ready && (idx == IW'(cur_len) + IW'(3));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  p_marker_r1: assert property (@(posedge clk) disable iff (rst)
    tx_valid && (idx == '0) |-> tx_data == SYNC);

  p_size_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    tx_valid && (idx == IW'(1)) |-> (tx_data == 8'(cur_len)) && (tx_data != 8'h00));

  p_status_size_r5: assert property (@(posedge clk) disable iff (rst)
    tx_valid && (idx == IW'(1)) && is_stat |-> tx_data == 8'd4);

  p_phase_range_r4: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> int'(phase) < PERIOD);

  p_replay_count_r7: assert property (@(posedge clk) disable iff (rst)
    frame_done && replaying |=> $stable(phase));

  p_no_intake_r10: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !tx_valid);
endmodule

bind ftx_framer ftx_framer_chk #(
  .IW(IW), .LW(LW), .PW(PW), .PERIOD(PERIOD), .SYNC(SYNC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .in_ready  (in_ready),
  .idx       (idx),
  .cur_len   (cur_len),
  .is_stat   (is_stat),
  .replaying (replaying),
  .phase     (phase)
);

// File: tb/sim_ftx_framer.sv
module sim_ftx_framer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic [7:0]  st_exp = 8'hF3;
  logic [7:0]  st_trits = 8'd17;
  logic [31:0] st_token = 32'd65535;
  logic        retx_req = 1'b0;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;

  int checks = 0;
  int errors = 0;
  int seen   = 0;
  int ph     = 0;
  bit done   = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] fb    [0:255];
  logic [7:0] lastd [0:255];
  int         lastn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ftx_framer u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .st_exp(st_exp),
    .st_trits(st_trits), .st_token(st_token), .retx_req(retx_req),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // expected frame from fb[0..n-1]
  task automatic push_frame(input int n, input string ptag);
    logic [15:0] c;
    logic [7:0]  b;
    c = 16'hFFFF;
    exp_q.push_back(8'hAA);   tag_q.push_back("R1 marker");
    exp_q.push_back(8'(n));   tag_q.push_back("R2 size");
    for (int i = 0; i <= n; i++) begin
      b = (i == 0) ? 8'(n) : fb[i-1];
      if (i > 0) begin exp_q.push_back(b); tag_q.push_back(ptag); end
      c = c ^ {b, 8'h00};
      for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    exp_q.push_back(c[15:8]); tag_q.push_back("R3 crc high");
    exp_q.push_back(c[7:0]);  tag_q.push_back("R3 crc low");
  endtask

  task automatic push_status();
    logic [31:0] tk;
    tk = st_token % 32'd65535;
    fb[0] = st_exp; fb[1] = st_trits; fb[2] = tk[15:8]; fb[3] = tk[7:0];
    push_frame(4, "R5/R6 status field");
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  // R1/R2 data payload; optional retransmit pulse mid collection (R8)
  task automatic send_data(input int n, input int seed, input bit use_last, input int retx_at);
    for (int i = 0; i < n; i++) fb[i] = 8'(seed + i * 37);
    for (int i = 0; i < n; i++) lastd[i] = fb[i];
    lastn = n;
    push_frame(n, "R1 payload");
    ph = (ph + 1) % 3;
    if (ph == 0) begin push_status(); ph = 1; end
    for (int i = 0; i < n; i++) begin
      if (i == retx_at) begin
        @(negedge clk); in_valid = 1'b0; retx_req = 1'b1;
        @(negedge clk); retx_req = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = lastd[i];
      in_last  = use_last && (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic do_retx();
    wait_idle();
    for (int i = 0; i < lastn; i++) fb[i] = lastd[i];
    push_frame(lastn, "R7 replay payload");
    @(negedge clk); retx_req = 1'b1;
    @(negedge clk); retx_req = 1'b0;
  endtask

  // monitor / scoreboard on the output side
  logic [15:0] lfsr = 16'hACE1;
  bit          prev_stall = 0;
  logic [7:0]  prev_data = '0;
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (prev_stall)
        chk(tx_valid && (tx_data == prev_data), "R9 hold under stall", int'(tx_data), int'(prev_data));
      if (tx_valid && in_ready)
        chk(1'b0, "R10 in_ready while sending", 1, 0);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tx_ready = (lfsr[2:0] != 3'b000);
      if (tx_valid && tx_ready) begin
        seen++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected byte", int'(tx_data), -1);
        end else begin
          logic [7:0] e;
          string      t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(tx_data == e, t, int'(tx_data), int'(e));
        end
      end
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired, %0d bytes outstanding", exp_q.size());
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    chk(tx_valid == 1'b0, "R4 reset tx_valid", int'(tx_valid), 0);
    // first frame is a status frame with token 65535 -> 0 (R4, R6)
    push_status(); ph = 1;
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b0, "R4 status first, intake closed", int'(in_ready), 0);
    wait_idle();

    // R8: retransmit with nothing stored is dropped
    s0 = seen;
    @(negedge clk); retx_req = 1'b1;
    @(negedge clk); retx_req = 1'b0;
    repeat (40) @(negedge clk);
    chk(seen == s0, "R8 no frame stored", seen - s0, 0);
    chk(in_ready == 1'b1, "R8 intake open after dropped request", int'(in_ready), 1);

    send_data(3, 8'h11, 1'b1, -1);            // R1
    st_token = 32'd65536;                     // R6: status after next frame -> 1
    st_exp   = 8'h80;
    send_data(1, 8'h5A, 1'b1, -1);            // count hits 3 -> status (R4)
    do_retx();                                // R7: replay 1-byte frame
    send_data(255, 8'h03, 1'b0, -1);          // R2: auto-close at 255
    st_token = 32'hFFFF_FFFF;                 // R6 -> 0
    st_trits = 8'd0;
    send_data(5, 8'hC7, 1'b1, 2);             // R8: request mid collection dropped
    do_retx();                                // R7: replays 5-byte frame, not status
    send_data(2, 8'h00, 1'b1, -1);
    st_token = 32'd70000;                     // R6 -> 4465
    st_exp   = 8'h7F;
    send_data(4, 8'hAA, 1'b1, -1);            // R4 status follows
    wait_idle();
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all frames delivered", exp_q.size(), 0);
    chk(in_ready == 1'b1, "R7 count kept after replays", int'(in_ready), 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule